// File: doc/BRIEF.md
# SPI Slave Transfer-Request and Flow-Hold Sequencer

This block sits beside the shift register of an SPI slave and decides when the slave may ask the master for a transfer, and how. Two wiring variants are supported and chosen per request by a mode input. In the five-wire variant the slave raises a dedicated active-high interrupt line for a programmable number of clock cycles. In the four-wire variant there is no interrupt line. The slave instead pulls the shared open-drain select line low itself. Before doing so it turns off its own shifter, so that it never answers its own select while other slaves on the bus may be selected. It keeps the shifter off until its pull-down has had time to clear through the input synchroniser.

A second, independent path lets the slave keep the select line low during a master access. This delays the master's next access until the slave lets go. Such a hold is never treated as a transfer request: it raises no interrupt, produces no completion pulse, and does not move the request sequencer. Frame content and the shifter itself are handled elsewhere. The shifter enable from this block also gates the MISO driver. Because a request is only launched while the line is idle, a slave frame always starts with the first byte of an access.

The request sequencer has seven states. IDLE waits for a pending request. GATE is a four-wire only cycle with the shifter off. PULSE drives the interrupt or the pull-down. SETTLE is a four-wire only wait with the shifter still off. WAIT looks for the master's select. ACCESS covers the master transfer. DONE issues a one-cycle completion pulse. The transitions are:
- IDLE→PULSE (five-wire start) or IDLE→GATE (four-wire start), taken when a request is pending, select is high and no master access is open.
- GATE→PULSE after one cycle.
- PULSE→WAIT (five-wire) or PULSE→SETTLE (four-wire) when the width count expires.
- SETTLE→ACCESS if select is low when the settle count expires, otherwise SETTLE→WAIT.
- WAIT→ACCESS when select is low.
- ACCESS→DONE when select is high.
- DONE→IDLE after one cycle.

The flow-hold path has two states, OFF and HOLD. OFF→HOLD is taken on a flow request inside an access window. HOLD→OFF is taken on a release.

Top module: `spi_slv_reqgen`

## Requirements
- R1: A request is launched from IDLE only when the synchronised select input `sel_n` is 1 (idle) and no master access is open. A request pulsed on `data_pend` while `sel_n` is 0 stays pending and is launched once the line is high again.
- R2: With `wire4_mode`=0, `irq_o` is 1 for exactly max(`t2_cycles`,1) consecutive cycles. It rises two cycles after the `data_pend` pulse when launch conditions hold. `sel_pull_o` and `cell_en_o` are unaffected.
- R3: With `wire4_mode`=1, `cell_en_o` goes to 0 one cycle before `sel_pull_o` goes to 1. `sel_pull_o` then stays 1 for exactly max(`t2_cycles`,1) cycles, and `irq_o` stays 0.
- R4: In four-wire mode `cell_en_o` stays 0 for SETTLE_CYC cycles after `sel_pull_o` drops, and returns to 1 on entering WAIT or ACCESS.
- R5: If the master already holds select low when the settle period ends (both sides asked together), the sequencer enters ACCESS directly and completes on the next rise of select.
- R6: `flow_req` is accepted only while a master access is open or the sequencer is in ACCESS. Once accepted, `sel_pull_o` stays 1 until `flow_release`, also after the master lets go. `flow_req` outside that window leaves `sel_pull_o` at 0.
- R7: A flow hold never raises `irq_o` or `req_done_o` and never launches a request.
- R8: `req_done_o` is a single-cycle pulse, issued the cycle after `sel_n` is seen high in ACCESS.
- R9: `access_o` goes to 1 the cycle after a falling edge of `sel_n` seen in IDLE, and goes to 0 the cycle after `sel_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_pend | input | 1 | One-cycle pulse: slave has data and wants a transfer |
| flow_req | input | 1 | One-cycle pulse: start a flow hold |
| flow_release | input | 1 | One-cycle pulse: end a flow hold |
| sel_n | input | 1 | Synchronised select line level, 1 = idle |
| wire4_mode | input | 1 | 1 = four-wire (pull select), 0 = five-wire (interrupt) |
| t2_cycles | input | CNT_W | Request pulse width in clock cycles, 0 treated as 1 |
| irq_o | output | 1 | Active-high request interrupt (five-wire) |
| sel_pull_o | output | 1 | Drive the open-drain select line low |
| cell_en_o | output | 1 | Shifter and MISO driver enable |
| req_done_o | output | 1 | One-cycle pulse: requested transfer finished |
| access_o | output | 1 | A master-initiated access is open |

## Verification
The hardest situation to reach is the four-wire simultaneous start. The master has to grab the line while the slave's own pull-down still holds it low, so the slave never sees a falling edge and can only tell from the level once its settle time has run out. The stimulus drives the master's select low a few cycles into the slave's pulse and holds it past the settle window. The bench wires the select input as the AND of the master drive and the slave's own pull-down, so the slave's drive feeds back exactly as on the shared line. The flow hold outliving the master's release is reached the same way, by releasing the master while the hold is set.

// File: rtl/spi_slv_reqgen_pkg.sv
package spi_slv_reqgen_pkg;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_GATE,
        RQ_PULSE,
        RQ_SETTLE,
        RQ_WAIT,
        RQ_ACCESS,
        RQ_DONE
    } rq_state_e;

    typedef enum logic {
        FL_OFF,
        FL_HOLD
    } fl_state_e;

endpackage

// File: rtl/sel_edge_track.sv
module sel_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic fsm_idle,
    output logic sel_fall,
    output logic sel_rise,
    output logic access_q
);

    logic sel_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev <= 1'b1;
        end else begin
            sel_prev <= sel_n;
        end
    end

    assign sel_fall = sel_prev & ~sel_n;
    assign sel_rise = ~sel_prev & sel_n;

    // access opened by the master: only counts when no request is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            access_q <= 1'b0;
        end else if (fsm_idle && sel_fall) begin
            access_q <= 1'b1;
        end else if (sel_rise) begin
            access_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/flow_hold_ctl.sv
module flow_hold_ctl
    import spi_slv_reqgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flow_req,
    input  logic flow_release,
    input  logic window,
    output logic hold_o
);

    fl_state_e fl_state, fl_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_state <= FL_OFF;
        end else begin
            fl_state <= fl_next;
        end
    end

    always_comb begin
        fl_next = fl_state;
        unique case (fl_state)
            FL_OFF:  if (flow_req && window) fl_next = FL_HOLD;
            FL_HOLD: if (flow_release)       fl_next = FL_OFF;
            default: fl_next = FL_OFF;
        endcase
    end

    always_comb begin
        hold_o = (fl_state == FL_HOLD);
    end

endmodule

// File: rtl/spi_slv_reqgen.sv
module spi_slv_reqgen
    import spi_slv_reqgen_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SETTLE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_pend,
    input  logic             flow_req,
    input  logic             flow_release,
    input  logic             sel_n,
    input  logic             wire4_mode,
    input  logic [CNT_W-1:0] t2_cycles,
    output logic             irq_o,
    output logic             sel_pull_o,
    output logic             cell_en_o,
    output logic             req_done_o,
    output logic             access_o
);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] ONE_LD    = CNT_W'(1);

    rq_state_e        state, state_next;
    logic             pend_q;
    logic             mode4_q;
    logic             start;
    logic             sel_fall, sel_rise;
    logic             flow_hold;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic [CNT_W-1:0] t2_eff;

    sel_edge_track u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .fsm_idle (state == RQ_IDLE),
        .sel_fall (sel_fall),
        .sel_rise (sel_rise),
        .access_q (access_o)
    );

    flow_hold_ctl u_flow (
        .clk          (clk),
        .rst_n        (rst_n),
        .flow_req     (flow_req),
        .flow_release (flow_release),
        .window       (access_o || (state == RQ_ACCESS)),
        .hold_o       (flow_hold)
    );

    pulse_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    assign t2_eff = (t2_cycles == '0) ? ONE_LD : t2_cycles;
    assign start  = (state == RQ_IDLE) && pend_q && sel_n && !access_o;

    // timer is reused: request width first, then the four-wire settle time
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = t2_eff;
        if (start && !wire4_mode) begin
            tmr_load = 1'b1;
        end else if (state == RQ_GATE) begin
            tmr_load = 1'b1;
        end else if ((state == RQ_PULSE) && tmr_expire && mode4_q) begin
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            mode4_q <= 1'b0;
        end else begin
            pend_q <= data_pend | (pend_q & ~start);
            if (start) begin
                mode4_q <= wire4_mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RQ_IDLE;
        end else begin
            state <= state_next;
        end
    end

    always_comb begin
        state_next = state;
        unique case (state)
            RQ_IDLE: begin
                if (start) state_next = wire4_mode ? RQ_GATE : RQ_PULSE;
            end
            RQ_GATE: begin
                state_next = RQ_PULSE;
            end
            RQ_PULSE: begin
                if (tmr_expire) state_next = mode4_q ? RQ_SETTLE : RQ_WAIT;
            end
            RQ_SETTLE: begin
                if (tmr_expire) state_next = sel_n ? RQ_WAIT : RQ_ACCESS;
            end
            RQ_WAIT: begin
                if (!sel_n) state_next = RQ_ACCESS;
            end
            RQ_ACCESS: begin
                if (sel_n) state_next = RQ_DONE;
            end
            RQ_DONE: begin
                state_next = RQ_IDLE;
            end
            default: state_next = RQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o      = 1'b0;
        sel_pull_o = flow_hold;
        cell_en_o  = 1'b1;
        req_done_o = 1'b0;
        unique case (state)
            RQ_IDLE, RQ_WAIT, RQ_ACCESS: ;
            RQ_GATE:   cell_en_o = 1'b0;
            RQ_PULSE: begin
                if (mode4_q) begin
                    sel_pull_o = 1'b1;
                    cell_en_o  = 1'b0;
                end else begin
                    irq_o = 1'b1;
                end
            end
            RQ_SETTLE: cell_en_o  = 1'b0;
            RQ_DONE:   req_done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_slv_reqgen_chk.sv
module spi_slv_reqgen_chk
    import spi_slv_reqgen_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      sel_n,
    input rq_state_e state,
    input logic      mode4_q,
    input logic      flow_hold,
    input logic      irq_o,
    input logic      sel_pull_o,
    input logic      cell_en_o,
    input logic      req_done_o,
    input logic      access_o
);

    p_irq_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(sel_n));

    p_gate_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cell_en_o) |-> $past(sel_n));

    p_irq_five_wire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !mode4_q);

    p_cell_off_in_pull_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RQ_PULSE && mode4_q) |-> (!cell_en_o && sel_pull_o && !irq_o));

    p_cell_off_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RQ_SETTLE) |-> !cell_en_o);

    p_flow_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flow_hold) |-> $past(access_o || state == RQ_ACCESS));

    p_flow_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flow_hold |-> !irq_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done_o |=> !req_done_o);

    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done_o |-> $past(state == RQ_ACCESS && sel_n));

    p_access_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_o) |-> $past(!sel_n));

endmodule

bind spi_slv_reqgen spi_slv_reqgen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .state      (state),
    .mode4_q    (mode4_q),
    .flow_hold  (flow_hold),
    .irq_o      (irq_o),
    .sel_pull_o (sel_pull_o),
    .cell_en_o  (cell_en_o),
    .req_done_o (req_done_o),
    .access_o   (access_o)
);

// File: tb/spi_slv_reqgen_test.sv
`timescale 1ns/1ps
module spi_slv_reqgen_test;

    localparam int CNT_W  = 8;
    localparam int SETTLE = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_pend = 1'b0;
    logic             flow_req = 1'b0;
    logic             flow_release = 1'b0;
    logic             m_low = 1'b0;
    logic             wire4_mode = 1'b0;
    logic [CNT_W-1:0] t2_cycles = 8'd5;
    logic             sel_n;
    logic             irq_o, sel_pull_o, cell_en_o, req_done_o, access_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    // shared open-drain select line
    assign sel_n = ~(m_low | sel_pull_o);

    spi_slv_reqgen #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .data_pend(data_pend), .flow_req(flow_req),
        .flow_release(flow_release), .sel_n(sel_n), .wire4_mode(wire4_mode),
        .t2_cycles(t2_cycles), .irq_o(irq_o), .sel_pull_o(sel_pull_o),
        .cell_en_o(cell_en_o), .req_done_o(req_done_o), .access_o(access_o)
    );

    // behavioural reference: phase 0 idle,1 gate,2 pulse,3 settle,4 wait,5 access,6 done
    int m_ph = 0, m_rem = 0, m_sc = 0;
    bit m_mode4 = 0, m_pend = 0, m_acc = 0, m_prev = 1, m_hold = 0;

    function automatic bit exp_irq();  return (m_ph == 2) && !m_mode4; endfunction
    function automatic bit exp_pull(); return ((m_ph == 2) && m_mode4) || m_hold; endfunction
    function automatic bit exp_cell(); return !(m_mode4 && (m_ph >= 1) && (m_ph <= 3)); endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_rem = 0; m_sc = 0; m_mode4 = 0;
            m_pend = 0; m_acc = 0; m_prev = 1; m_hold = 0;
        end else begin
            bit line, fall, rise, window, go;
            int t2e;
            line   = !(m_low || exp_pull());
            fall   = m_prev && !line;
            rise   = !m_prev && line;
            window = m_acc || (m_ph == 5);
            t2e    = (t2_cycles == 0) ? 1 : int'(t2_cycles);
            go     = (m_ph == 0) && m_pend && line && !m_acc;
            if (!m_hold && flow_req && window) m_hold = 1;
            else if (m_hold && flow_release)   m_hold = 0;
            if (m_ph == 0 && fall) m_acc = 1;
            else if (rise)         m_acc = 0;
            m_pend = data_pend || (m_pend && !go);
            m_prev = line;
            case (m_ph)
                0: if (go) begin
                       m_mode4 = wire4_mode;
                       if (wire4_mode) m_ph = 1;
                       else begin m_ph = 2; m_rem = t2e; end
                   end
                1: begin m_ph = 2; m_rem = t2e; end
                2: if (m_rem == 1) begin
                       if (m_mode4) begin m_ph = 3; m_sc = SETTLE; end
                       else m_ph = 4;
                   end else m_rem--;
                3: if (m_sc == 1) m_ph = line ? 4 : 5; else m_sc--;
                4: if (!line) m_ph = 5;
                5: if (line) m_ph = 6;
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, expv);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        chk(irq_o == exp_irq(),      "R2 irq_o",      int'(irq_o),      int'(exp_irq()));
        chk(sel_pull_o == exp_pull(), "R3 sel_pull_o", int'(sel_pull_o), int'(exp_pull()));
        chk(cell_en_o == exp_cell(),  "R4 cell_en_o",  int'(cell_en_o),  int'(exp_cell()));
        chk(req_done_o == (m_ph == 6), "R8 req_done_o", int'(req_done_o), int'(m_ph == 6));
        chk(access_o == m_acc,        "R9 access_o",   int'(access_o),   int'(m_acc));
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_pend();
        data_pend = 1'b1; step(1); data_pend = 1'b0;
    endtask

    // which: 0 irq_o, 1 sel_pull_o, 2 req_done_o
    function automatic bit sig(input int which);
        case (which)
            0: return irq_o;
            1: return sel_pull_o;
            default: return req_done_o;
        endcase
    endfunction

    task automatic width_of(input int which, output int w);
        int guard = 0;
        w = 0;
        while (!sig(which) && guard < 80) begin step(1); guard++; end
        while (sig(which) && w < 300) begin w++; step(1); end
    endtask

    task automatic master_access(input int gap, input int len, output int dones);
        dones = 0;
        step(gap);
        m_low = 1'b1;
        for (int i = 0; i < len; i++) begin step(1); if (req_done_o) dones++; end
        m_low = 1'b0;
        for (int i = 0; i < 4; i++) begin step(1); if (req_done_o) dones++; end
    endtask

    int w, d, cnt;

    initial begin
        step(5);
        chk(irq_o == 0 && sel_pull_o == 0, "R2 reset irq/pull", int'({irq_o, sel_pull_o}), 0);
        chk(cell_en_o == 1 && access_o == 0, "R9 reset cell/access", int'({cell_en_o, access_o}), 2);
        rst_n = 1'b1;
        step(2);

        // R2: five-wire pulse width
        wire4_mode = 0; t2_cycles = 8'd5;
        pulse_pend();
        width_of(0, w);
        chk(w == 5, "R2 irq width t2=5", w, 5);
        master_access(3, 8, d);
        chk(d == 1, "R8 single done five-wire", d, 1);

        // R3/R4: four-wire pulse width and settle
        wire4_mode = 1; t2_cycles = 8'd4;
        pulse_pend();
        width_of(1, w);
        chk(w == 4, "R3 pull width t2=4", w, 4);
        chk(cell_en_o == 0, "R4 cell off right after pull", int'(cell_en_o), 0);
        step(SETTLE);
        chk(cell_en_o == 1, "R4 cell back on after settle", int'(cell_en_o), 1);
        master_access(2, 6, d);
        chk(d == 1, "R8 single done four-wire", d, 1);

        // R5: simultaneous start in four-wire mode
        t2_cycles = 8'd6;
        pulse_pend();
        while (!sel_pull_o) step(1);
        step(2);
        m_low = 1'b1;
        step(20);
        chk(cell_en_o == 1, "R5 cell enabled in joint access", int'(cell_en_o), 1);
        m_low = 1'b0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin step(1); if (req_done_o) cnt++; end
        chk(cnt == 1, "R5 joint access completes", cnt, 1);

        // R1: request while the master holds select stays pending
        wire4_mode = 0; t2_cycles = 8'd3;
        m_low = 1'b1;
        step(3);
        chk(access_o == 1, "R9 access opened by master", int'(access_o), 1);
        pulse_pend();
        cnt = 0;
        for (int i = 0; i < 10; i++) begin step(1); if (irq_o) cnt++; end
        chk(cnt == 0, "R1 no irq while select low", cnt, 0);
        m_low = 1'b0;
        step(2);
        chk(access_o == 0, "R9 access closed on rise", int'(access_o), 0);
        width_of(0, w);
        chk(w == 3, "R1 pending request launched after rise", w, 3);
        master_access(2, 5, d);

        // R6: flow request outside a window is ignored
        flow_req = 1'b1; step(1); flow_req = 1'b0;
        step(3);
        chk(sel_pull_o == 0, "R6 flow_req ignored outside access", int'(sel_pull_o), 0);

        // R6/R7: flow hold across master release
        m_low = 1'b1;
        step(3);
        flow_req = 1'b1; step(1); flow_req = 1'b0;
        step(3);
        m_low = 1'b0;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin step(1); if (irq_o || req_done_o) cnt++; end
        chk(sel_pull_o == 1, "R6 hold keeps select low", int'(sel_pull_o), 1);
        chk(access_o == 1, "R6 access still open under hold", int'(access_o), 1);
        chk(cnt == 0, "R7 hold raises no irq or done", cnt, 0);
        pulse_pend();
        step(4);
        chk(irq_o == 0, "R7 request waits behind hold", int'(irq_o), 0);
        flow_release = 1'b1; step(1); flow_release = 1'b0;
        step(1);
        chk(sel_pull_o == 0, "R6 hold released", int'(sel_pull_o), 0);
        t2_cycles = 8'd0;
        width_of(0, w);
        chk(w == 1, "R2 t2=0 gives one cycle", w, 1);
        master_access(2, 4, d);
        chk(d == 1, "R8 done after zero-width request", d, 1);

        step(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule